// File: doc/BRIEF.md
# Two-Channel Event Counting Unit

This unit counts processor events for profiling. It holds two counters that run independently of each other. Each counter has its own control register. That register picks which event the counter tracks, holds the two bits that must both be set before counting can happen, carries a flag that slows down the timebase, and has a bit that zeroes the count when written. The processor supplies a vector of single-cycle event pulses. Each bit position of that vector matches one event code. One code is not taken from the vector at all: it is an internal elapsed-time event that fires on every cycle the counter runs.

Software uses a plain register bus to set up the counters and to read them. Each count is split across two registers: a low register with the bottom bits and a high register with the rest. Reading the low register also captures the upper bits into a shadow copy. Because of that, a read of low followed by a read of high returns one consistent value, even while the counter keeps running. The unit raises no interrupt on wrap. At the full width a counter takes many days to wrap.

Top module: `evtcnt_unit`

## Requirements
- R1: There are two counters. Control registers sit at byte offsets 0x00 (counter 0) and 0x04 (counter 1). Writing one control register never changes the other counter or its register.
- R2: Control register layout. Bits [5:0] select the event, bit 8 is the slow-timebase flag, bit 13 clears the counter, bit 14 is the start bit and bit 15 is the enable bit. On readback, bit 13 and every undefined bit read as 0.
- R3: A counter advances only while both its start bit and its enable bit are 1. If either bit is 0, the counter holds its value.
- R4: A write with bit 13 set zeroes that counter on the same clock edge as the write. The clear takes priority over an increment in that cycle. No write can load any value other than zero.
- R5: For an external event code, the counter adds one for each running cycle in which event-vector bit [code] is 1.
- R6: The following codes never advance a counter, whatever the event vector carries: 0x00, 0x0C, 0x1B to 0x20, 0x26, and 0x2A to 0x3F.
- R7: Code 0x23 is the elapsed-time event. Event-vector bit 0x23 has no effect on it. With the slow flag at 0, the counter adds one on every running cycle. With the slow flag at 1, it adds one once per 8 running cycles, and a clear restarts that divide-by-8 phase.
- R8: Low registers sit at 0x14 (counter 0) and 0x1C (counter 1) and return count bits [LO_W-1:0]. High registers sit at 0x10 and 0x18 and return the upper count bits, zero-extended. Those upper bits are the copy captured at that counter's most recent low-register read. Read data appears on the cycle after rdEn.
- R9: A read from any address not listed in R1 or R8 returns zero.
- R10: A counter wraps from all ones to zero and signals nothing when it does.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| evtPulse | input | 64 | Event pulses; bit n belongs to event code n |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Byte address of the register |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Read data, registered |

## Verification
The bench builds the unit with a 16-bit count and a 12-bit low register. With those values, carries into the high register happen after 4096 events and a full wrap happens after 65536 cycles. Both fit in one run, whereas the default 48-bit width would never reach them. The narrower widths also let one elapsed-time run cross the low/high boundary, so the shadow capture is tested on a nonzero upper half. The bench then re-reads the high register after a clear to show that it returns the copy captured earlier, not the live count.

// File: rtl/perfcnt_pkg.sv
package perfcnt_pkg;

  localparam int NUM_CNT = 2;
  localparam int SEL_W   = 6;
  localparam int EVT_W   = 1 << SEL_W;

  // control field positions decoded by hardware
  localparam int SEL_LSB   = 0;
  localparam int SLOW_BIT  = 8;
  localparam int CLR_BIT   = 13;
  localparam int START_BIT = 14;
  localparam int EN_BIT    = 15;

  localparam logic [SEL_W-1:0] TIME_CODE = 6'h23;

  // register map, byte offsets
  localparam int CTL_BASE  = 'h00;
  localparam int CTL_STEP  = 'h04;
  localparam int CNT_BASE  = 'h10;
  localparam int CNT_STEP  = 'h08;
  localparam int LO_OFFSET = 'h04;

  typedef struct packed {
    logic             clr;
    logic             run;
    logic             slow;
    logic [SEL_W-1:0] sel;
  } cntCtl_t;

  function automatic logic codeValid(input logic [SEL_W-1:0] code);
    logic inRange, inHole;
    inRange = (code >= 6'h01) && (code <= 6'h29);
    inHole  = (code == 6'h0c) || (code == 6'h26) ||
              ((code >= 6'h1b) && (code <= 6'h20));
    return inRange && !inHole;
  endfunction

endpackage

// File: rtl/perfcnt_core.sv
module perfcnt_core
  import perfcnt_pkg::*;
#(
  parameter int CNT_W = 48,
  parameter int DIV_W = 3
) (
  input  logic                             clk,
  input  logic                             rstN,
  input  cntCtl_t [NUM_CNT-1:0]            ctl,
  input  logic [EVT_W-1:0]                 evtPulse,
  output logic [NUM_CNT-1:0][CNT_W-1:0]    count
);

  for (genvar g = 0; g < NUM_CNT; g++) begin : gCnt
    logic [CNT_W-1:0] cntQ;
    logic [DIV_W-1:0] divQ;
    logic isTime, timeTick, hit;

    assign isTime   = ctl[g].sel == TIME_CODE;
    assign timeTick = ctl[g].slow ? (&divQ) : 1'b1;
    assign hit      = ctl[g].run && codeValid(ctl[g].sel) &&
                      (isTime ? timeTick : evtPulse[ctl[g].sel]);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        cntQ <= '0;
        divQ <= '0;
      end else if (ctl[g].clr) begin
        cntQ <= '0;
        divQ <= '0;
      end else begin
        if (ctl[g].run && isTime) divQ <= divQ + 1'b1;
        if (hit)                  cntQ <= cntQ + 1'b1;
      end
    end

    assign count[g] = cntQ;
  end

endmodule

// File: rtl/perfcnt_regs.sv
module perfcnt_regs
  import perfcnt_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          wrEn,
  input  logic                          rdEn,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             wrData,
  input  logic [NUM_CNT-1:0][CNT_W-1:0] count,
  output cntCtl_t [NUM_CNT-1:0]         ctl,
  output logic [DATA_W-1:0]             rdData
);

  localparam int HI_W = CNT_W - LO_W;

  logic [SEL_W-1:0] selQ   [NUM_CNT];
  logic             slowQ  [NUM_CNT];
  logic             startQ [NUM_CNT];
  logic             enQ    [NUM_CNT];
  logic [HI_W-1:0]  shadowQ[NUM_CNT];
  logic [DATA_W-1:0] rdNext;
  logic              unusedWr;

  assign unusedWr = ^wrData;

  function automatic logic [ADDR_W-1:0] ctlAdr(input int i);
    return ADDR_W'(CTL_BASE + i * CTL_STEP);
  endfunction
  function automatic logic [ADDR_W-1:0] hiAdr(input int i);
    return ADDR_W'(CNT_BASE + i * CNT_STEP);
  endfunction
  function automatic logic [ADDR_W-1:0] loAdr(input int i);
    return ADDR_W'(CNT_BASE + i * CNT_STEP + LO_OFFSET);
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < NUM_CNT; i++) begin
      if (!rstN) begin
        selQ[i]    <= '0;
        slowQ[i]   <= 1'b0;
        startQ[i]  <= 1'b0;
        enQ[i]     <= 1'b0;
        shadowQ[i] <= '0;
      end else begin
        if (wrEn && addr == ctlAdr(i)) begin
          selQ[i]   <= wrData[SEL_LSB +: SEL_W];
          slowQ[i]  <= wrData[SLOW_BIT];
          startQ[i] <= wrData[START_BIT];
          enQ[i]    <= wrData[EN_BIT];
        end
        if (rdEn && addr == loAdr(i))
          shadowQ[i] <= count[i][CNT_W-1:LO_W];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NUM_CNT; i++) begin
      ctl[i].clr  = wrEn && (addr == ctlAdr(i)) && wrData[CLR_BIT];
      ctl[i].run  = startQ[i] && enQ[i];
      ctl[i].slow = slowQ[i];
      ctl[i].sel  = selQ[i];
    end
  end

  always_comb begin
    rdNext = '0;
    for (int i = 0; i < NUM_CNT; i++) begin
      if (addr == ctlAdr(i)) begin
        rdNext[SEL_LSB +: SEL_W] = selQ[i];
        rdNext[SLOW_BIT]         = slowQ[i];
        rdNext[START_BIT]        = startQ[i];
        rdNext[EN_BIT]           = enQ[i];
      end
      if (addr == hiAdr(i)) rdNext = DATA_W'(shadowQ[i]);
      if (addr == loAdr(i)) rdNext = DATA_W'(count[i][LO_W-1:0]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)     rdData <= '0;
    else if (rdEn) rdData <= rdNext;
  end

endmodule

// File: rtl/evtcnt_unit.sv
module evtcnt_unit
  import perfcnt_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int LO_W   = 32,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int DIV_W  = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [63:0]       evtPulse,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData
);

  cntCtl_t [NUM_CNT-1:0]          ctl;
  logic [NUM_CNT-1:0][CNT_W-1:0]  count;

  perfcnt_regs #(
    .CNT_W(CNT_W), .LO_W(LO_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) uRegs (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .count(count), .ctl(ctl), .rdData(rdData)
  );

  perfcnt_core #(
    .CNT_W(CNT_W), .DIV_W(DIV_W)
  ) uCore (
    .clk(clk), .rstN(rstN), .ctl(ctl), .evtPulse(evtPulse), .count(count)
  );

endmodule

// File: rtl/evtcnt_chk.sv
module evtcnt_chk
  import perfcnt_pkg::*;
#(
  parameter int CNT_W  = 48,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32
) (
  input logic                          clk,
  input logic                          rstN,
  input logic                          rdEn,
  input logic [ADDR_W-1:0]             addr,
  input logic [DATA_W-1:0]             rdData,
  input cntCtl_t [NUM_CNT-1:0]         ctl,
  input logic [NUM_CNT-1:0][CNT_W-1:0] count
);

  logic mapped;
  assign mapped = (addr == 8'h00) || (addr == 8'h04) || (addr == 8'h10) ||
                  (addr == 8'h14) || (addr == 8'h18) || (addr == 8'h1c);

  assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && !mapped |=> rdData == '0);

  assert_clear_reads_zero_R2: assert property (@(posedge clk) disable iff (!rstN)
    rdEn && (addr == 8'h00 || addr == 8'h04) |=> rdData[CLR_BIT] == 1'b0);

  for (genvar g = 0; g < NUM_CNT; g++) begin : gChk
    assert_clear_wins_R4: assert property (@(posedge clk) disable iff (!rstN)
      ctl[g].clr |=> count[g] == '0);

    assert_hold_stopped_R3: assert property (@(posedge clk) disable iff (!rstN)
      !ctl[g].run && !ctl[g].clr |=> $stable(count[g]));

    assert_bad_code_idle_R6: assert property (@(posedge clk) disable iff (!rstN)
      ctl[g].run && !codeValid(ctl[g].sel) && !ctl[g].clr |=> $stable(count[g]));

    assert_single_step_R5: assert property (@(posedge clk) disable iff (!rstN)
      !ctl[g].clr |=> (count[g] == $past(count[g])) ||
                      (count[g] == $past(count[g]) + CNT_W'(1)));

    assert_time_every_cycle_R7: assert property (@(posedge clk) disable iff (!rstN)
      ctl[g].run && ctl[g].sel == TIME_CODE && !ctl[g].slow && !ctl[g].clr
      |=> count[g] == $past(count[g]) + CNT_W'(1));
  end

endmodule

bind evtcnt_unit evtcnt_chk #(
  .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
) uChk (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .addr(addr), .rdData(rdData),
  .ctl(ctl), .count(count)
);

// File: tb/tb_evtcnt_unit.sv
module tb_evtcnt_unit;

  localparam int TB_CNT = 16;
  localparam int TB_LO  = 12;
  localparam int LOMASK = (1 << TB_LO) - 1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [63:0] evtPulse = '0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;

  int vecCnt = 0;
  int missCnt = 0;
  logic [31:0] expQ[$];
  string       tagQ[$];
  logic        pendRd = 1'b0;
  logic        done = 1'b0;

  always #10 clk = ~clk;

  evtcnt_unit #(.CNT_W(TB_CNT), .LO_W(TB_LO)) dut (
    .clk(clk), .rstN(rstN), .evtPulse(evtPulse), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData)
  );

  // monitor: result is registered on the edge that sampled rdEn
  always @(posedge clk) pendRd <= rdEn;
  always @(negedge clk) begin
    if (pendRd) begin
      logic [31:0] e;
      string t;
      e = expQ.pop_front();
      t = tagQ.pop_front();
      vecCnt++;
      if (rdData !== e) begin
        missCnt++;
        $display("FAIL %s actual %h expected %h", t, rdData, e);
      end
    end
  end

  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0; wrData = '0;
  endtask

  task automatic readReg(input logic [7:0] a, input logic [31:0] e, input string t);
    rdEn = 1'b1; addr = a;
    expQ.push_back(e);
    tagQ.push_back(t);
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic pulse(input int code, input int n);
    evtPulse[code] = 1'b1;
    repeat (n) @(negedge clk);
    evtPulse[code] = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      missCnt++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
      $finish;
    end
  end

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(1);

    // reset state
    readReg(8'h00, 32'h0, "R2 reset ctl0");
    readReg(8'h14, 32'h0, "R8 reset lo0");
    readReg(8'h18, 32'h0, "R8 reset hi1");

    // R7: elapsed time every cycle for 5000 cycles, bit 0x23 of the vector held high
    evtPulse[35] = 1'b1;
    writeReg(8'h00, 32'hC023);
    idle(4999);
    writeReg(8'h00, 32'h0023);
    evtPulse[35] = 1'b0;
    readReg(8'h14, 5000 & LOMASK, "R7 R8 lo0 elapsed");
    readReg(8'h10, 5000 >> TB_LO, "R8 hi0 carry");
    readReg(8'h00, 32'h0023, "R2 ctl0 readback");
    readReg(8'h04, 32'h0, "R1 ctl1 untouched");
    readReg(8'h1c, 32'h0, "R1 lo1 untouched");

    // R8: high register returns the shadow, not the live count
    writeReg(8'h00, 32'h2023);
    readReg(8'h10, 5000 >> TB_LO, "R8 hi0 shadow stale");
    readReg(8'h14, 32'h0, "R4 lo0 cleared");
    readReg(8'h10, 32'h0, "R8 hi0 shadow refreshed");

    // R2: clear bit and undefined bits read back as zero
    writeReg(8'h00, 32'h3FE3);
    readReg(8'h00, 32'h0123, "R2 reserved and clear read 0");

    // R3: start alone, enable alone, then both, then hold
    writeReg(8'h00, 32'h4023);
    idle(20);
    writeReg(8'h00, 32'h0023);
    readReg(8'h14, 32'h0, "R3 start only");
    writeReg(8'h00, 32'h8023);
    idle(20);
    writeReg(8'h00, 32'h0023);
    readReg(8'h14, 32'h0, "R3 enable only");
    writeReg(8'h00, 32'hC023);
    idle(9);
    writeReg(8'h00, 32'h0023);
    idle(30);
    readReg(8'h14, 32'd10, "R3 hold after stop");

    // R4: clear while running beats the increment
    writeReg(8'h00, 32'hE023);
    writeReg(8'h00, 32'h0023);
    readReg(8'h14, 32'd1, "R4 clear wins");

    // R7: slow timebase, 40 running cycles -> 5
    writeReg(8'h00, 32'h2000);
    writeReg(8'h00, 32'hC123);
    idle(39);
    writeReg(8'h00, 32'h0123);
    readReg(8'h14, 32'd5, "R7 slow divide by 8");

    // R5 and R1: counter 1 on code 0x11
    writeReg(8'h04, 32'hE011);
    pulse(17, 7);
    idle(3);
    pulse(16, 4);
    pulse(17, 5);
    writeReg(8'h04, 32'h0011);
    readReg(8'h1c, 32'd12, "R5 lo1 event count");
    readReg(8'h18, 32'h0, "R5 hi1");
    readReg(8'h14, 32'd5, "R1 lo0 independent");

    // R6: unused codes never count
    writeReg(8'h04, 32'hE00C);
    pulse(12, 6);
    readReg(8'h1c, 32'h0, "R6 code 0x0C");
    writeReg(8'h04, 32'hC000);
    pulse(0, 6);
    readReg(8'h1c, 32'h0, "R6 code 0x00");
    writeReg(8'h04, 32'hC026);
    pulse(38, 6);
    readReg(8'h1c, 32'h0, "R6 code 0x26");
    writeReg(8'h04, 32'hC01B);
    pulse(27, 6);
    readReg(8'h1c, 32'h0, "R6 code 0x1B");
    writeReg(8'h04, 32'hC02A);
    pulse(42, 6);
    readReg(8'h1c, 32'h0, "R6 code 0x2A");
    writeReg(8'h04, 32'h0000);

    // R9: unmapped addresses
    readReg(8'h08, 32'h0, "R9 addr 0x08");
    readReg(8'h0c, 32'h0, "R9 addr 0x0C");
    readReg(8'h20, 32'h0, "R9 addr 0x20");
    readReg(8'h02, 32'h0, "R9 addr 0x02");

    // R10: run past a full wrap, 65539 cycles -> 3
    writeReg(8'h00, 32'hE023);
    idle(65538);
    writeReg(8'h00, 32'h0023);
    readReg(8'h14, 32'd3, "R10 lo0 after wrap");
    readReg(8'h10, 32'h0, "R10 hi0 after wrap");

    idle(3);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, missCnt);
    $finish;
  end

endmodule